// File: doc/BRIEF.md
# Four-Wire Serial Byte Receiver with Data/Command Select

This block is the receive side of a four-wire serial link from a host. The host drives four pins: an active-low chip select, a serial clock, a serial data line and a separate data/command select line. The receiver runs on its own system clock. It passes every pin through a synchroniser and finds the rising edges of the serial clock by oversampling. It builds 8-bit bytes, most significant bit first, from the data line.

When a byte is complete, the block raises a valid strobe for one system-clock cycle. The strobe comes with the byte and a one-bit tag. The tag is the level of the data/command select pin at the eighth rising edge of that byte: low marks a command and high marks data. A downstream decoder takes the byte and tag in the cycle of the strobe. There is no back-pressure.

A byte is lost if chip select goes high before its eighth edge, or if reset arrives during it. The next session always starts on a byte boundary. A byte that was already complete before chip select went high is still delivered, so the host may pause between bytes.

Top module: `spi4_byte_rx`

## Requirements
- R1: While reset is applied, and in the cycles after it, `byte_valid` is 0, `byte_data` is 0 and `byte_is_data` is 0.
- R2: With chip select low, eight rising edges of the serial clock assemble one byte. The first sampled bit is bit 7 and the last is bit 0. The byte appears on `byte_data` with a `byte_valid` pulse.
- R3: `byte_is_data` equals the level of `dc_sel` at the eighth rising edge of the byte (0 = command, 1 = data). The level of `dc_sel` on the first seven edges has no effect.
- R4: If chip select stays low after a byte, the next rising edge is taken as bit 7 of the following byte, so back-to-back bytes are received without gaps.
- R5: If chip select rises after one to seven edges of a byte, that partial byte produces no output. The next byte after chip select falls again is assembled from its first edge.
- R6: While chip select is high, serial-clock edges produce no output and do not advance the bit position.
- R7: A reset during a byte discards that partial byte. After reset, the next byte is assembled from its first edge.
- R8: `byte_valid` is never high in two consecutive system-clock cycles.
- R9: A byte completed before chip select rises is delivered, and a later session after the pause is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host; data sampled on its rising edge |
| mosi | input | 1 | Serial data from the host, MSB first |
| dc_sel | input | 1 | Data/command select pin, sampled on the eighth edge (0 = command, 1 = data) |
| byte_valid | output | 1 | One-cycle strobe marking a completed byte |
| byte_data | output | BYTE_W | Last completed byte |
| byte_is_data | output | 1 | Tag of the last completed byte (1 = data, 0 = command) |

## Verification
The hardest situation to reach from the pins is a session aborted at each possible bit position. Chip select must rise after exactly one, two and so on up to seven edges, and the following byte must then show that the bit position really went back to zero. The stimulus sends k bits of all-ones for each k from 1 to 7, toggles chip select, and sends a full byte whose value would be visibly shifted if any stale bit survived. A reset during a half-sent byte gets the same treatment. A sweep of all 256 byte values with both tags, back to back in a single session, covers assembly order and tag capture.

// File: rtl/spi4_rx_pkg.sv
`timescale 1ns/1ps
package spi4_rx_pkg;

  // Host pins bundled for a common synchroniser.
  typedef struct packed {
    logic cs_n;
    logic sclk;
    logic mosi;
    logic dc;
  } pin_bus_t;

  localparam int unsigned PIN_W = $bits(pin_bus_t);

  // Idle levels loaded into the synchroniser on reset: deselected.
  localparam pin_bus_t PIN_IDLE = '{cs_n: 1'b1, sclk: 1'b0, mosi: 1'b0, dc: 1'b0};

endpackage

// File: rtl/spi4_rx_rstsync.sv
`timescale 1ns/1ps
module spi4_rx_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/spi4_rx_sync.sv
`timescale 1ns/1ps
module spi4_rx_sync #(
  parameter int unsigned        STAGES  = 2,
  parameter int unsigned        W       = 4,
  parameter logic [W-1:0]       RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      always_comb stg_d = din;
    end else begin : g_next
      always_comb stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else        stg_q[s] <= stg_d;
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/spi4_rx_shift.sv
`timescale 1ns/1ps
module spi4_rx_shift #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic              dc_s,
  output logic              valid,
  output logic [BYTE_W-1:0] data,
  output logic              is_data
);

  localparam int unsigned         CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0]    LAST  = CNT_W'(BYTE_W - 1);

  logic              sclk_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-2:0] sh_q, sh_d;
  logic              valid_q, valid_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              tag_q, tag_d;
  logic              rise;
  logic              take;
  logic              load;

  assign rise = sclk_s & ~sclk_q;
  assign take = rise & ~cs_n_s;
  assign load = take & (cnt_q == LAST);

  // Next-state logic.
  always_comb begin
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    valid_d = 1'b0;
    data_d  = data_q;
    tag_d   = tag_q;
    if (cs_n_s) begin
      cnt_d = '0;
    end else if (take) begin
      sh_d = {sh_q[BYTE_W-3:0], mosi_s};
      if (load) begin
        cnt_d   = '0;
        valid_d = 1'b1;
        data_d  = {sh_q, mosi_s};
        tag_d   = dc_s;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  // Edge detector reference; resets high so no false edge follows reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b1;
    else        sclk_q <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sh_q <= '0;
    else if (take) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      tag_q  <= 1'b0;
    end else if (load) begin
      data_q <= data_d;
      tag_q  <= tag_d;
    end
  end

  assign valid   = valid_q;
  assign data    = data_q;
  assign is_data = tag_q;

  // A deselected cycle leaves the bit position at zero.
  assert_cnt_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (cnt_q == '0));

  // An eighth accepted edge yields a strobe on the next cycle.
  assert_eighth_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !cs_n_s && (cnt_q == LAST)) |=> valid_q);

  // Any earlier accepted edge advances the position by one, without a strobe.
  assert_cnt_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !cs_n_s && (cnt_q != LAST)) |=> (!valid_q && (cnt_q == $past(cnt_q) + CNT_W'(1))));

  // A strobe only follows a selected cycle.
  assert_strobe_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(!cs_n_s));

  // The strobe never lasts two cycles.
  assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

endmodule

// File: rtl/spi4_byte_rx.sv
`timescale 1ns/1ps
module spi4_byte_rx
  import spi4_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              dc_sel,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_is_data
);

  logic     rst_n_int;
  pin_bus_t pins_raw;
  pin_bus_t pins_s;

  spi4_rx_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  always_comb begin
    pins_raw.cs_n = cs_n;
    pins_raw.sclk = sclk;
    pins_raw.mosi = mosi;
    pins_raw.dc   = dc_sel;
  end

  spi4_rx_sync #(
    .STAGES  (SYNC_STAGES),
    .W       (PIN_W),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .din   (pins_raw),
    .dout  (pins_s)
  );

  spi4_rx_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .cs_n_s  (pins_s.cs_n),
    .sclk_s  (pins_s.sclk),
    .mosi_s  (pins_s.mosi),
    .dc_s    (pins_s.dc),
    .valid   (byte_valid),
    .data    (byte_data),
    .is_data (byte_is_data)
  );

endmodule

// File: tb/tb_spi4_byte_rx.sv
`timescale 1ns/1ps
module tb_spi4_byte_rx;

  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       mosi = 1'b0;
  logic       dc_sel = 1'b0;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic       byte_is_data;

  int n_chk = 0;
  int n_fail = 0;
  int dbl = 0;
  bit done = 1'b0;
  bit prev_v = 1'b0;
  logic [8:0] got_q[$];
  logic [8:0] exp_q[$];

  always #10 clk = ~clk;

  spi4_byte_rx dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .dc_sel(dc_sel), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_is_data(byte_is_data)
  );

  always @(negedge clk) begin
    if (byte_valid) got_q.push_back({byte_is_data, byte_data});
    if (byte_valid && prev_v) dbl++;
    prev_v = byte_valid;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send_bits(logic [7:0] b, int n, logic dc8, logic dcx);
    for (int i = 0; i < n; i++) begin
      mosi   = b[7-i];
      dc_sel = (i == 7) ? dc8 : dcx;
      tick(HALF);
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic set_cs(logic v);
    cs_n = v;
    tick(6);
  endtask

  task automatic compare(string req);
    tick(12);
    check({req, " count"}, got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size())
      for (int i = 0; i < exp_q.size(); i++) check(req, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  initial begin
    tick(3);
    // R1: outputs quiet while reset is held
    check("R1 valid", byte_valid, 0);
    check("R1 data", byte_data, 0);
    check("R1 tag", byte_is_data, 0);
    rst_n = 1'b1;
    tick(6);
    check("R1 valid after release", byte_valid, 0);

    // R2 R3 R4: every value with both tags, back to back in one session
    set_cs(1'b0);
    for (int v = 0; v < 256; v++)
      for (int t = 0; t < 2; t++) begin
        send_bits(8'(v), 8, t[0], ~t[0]);
        exp_q.push_back({t[0], 8'(v)});
      end
    set_cs(1'b1);
    compare("R2 R3 R4 sweep");

    // R6: edges while deselected are ignored and do not shift alignment
    send_bits(8'hA5, 8, 1'b1, 1'b0);
    send_bits(8'h5A, 5, 1'b0, 1'b1);
    compare("R6 deselected");
    set_cs(1'b0);
    send_bits(8'h3C, 8, 1'b1, 1'b0);
    exp_q.push_back(9'h13C);
    set_cs(1'b1);
    compare("R6 alignment after deselect");

    // R5: abort after each of 1..7 edges, then a full byte
    for (int k = 1; k < 8; k++) begin
      set_cs(1'b0);
      send_bits(8'hFF, k, 1'b1, 1'b1);
      set_cs(1'b1);
      set_cs(1'b0);
      send_bits(8'((k * 37) & 8'hFE), 8, k[0], ~k[0]);
      exp_q.push_back({k[0], 8'((k * 37) & 8'hFE)});
      set_cs(1'b1);
    end
    compare("R5 partial discard");

    // R9: pause after a complete byte, then resume
    set_cs(1'b0);
    send_bits(8'h81, 8, 1'b0, 1'b1);
    set_cs(1'b1);
    tick(20);
    set_cs(1'b0);
    send_bits(8'h7E, 8, 1'b1, 1'b0);
    set_cs(1'b1);
    exp_q.push_back(9'h081);
    exp_q.push_back(9'h17E);
    compare("R9 pause");

    // R7: reset in the middle of a byte, select held low
    set_cs(1'b0);
    send_bits(8'hF0, 4, 1'b1, 1'b1);
    rst_n = 1'b0;
    tick(3);
    check("R7 valid in reset", byte_valid, 0);
    check("R7 data cleared", byte_data, 0);
    rst_n = 1'b1;
    tick(8);
    send_bits(8'h55, 8, 1'b1, 1'b0);
    exp_q.push_back(9'h155);
    set_cs(1'b1);
    compare("R7 reset mid-byte");

    // R8: strobe never two cycles long
    check("R8 double strobe", dbl, 0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule